// File: doc/BRIEF.md
# Capture/Compare Timer with PWM

A 16-bit timer whose counter advances on a prescaled tick drawn from one of three sources: every system clock cycle, a single-cycle strobe from a fixed-rate clock generator, or rising edges of an external pin, which passes through a two-stage synchronizer first. The counter either wraps at a programmable modulo (up-only) or climbs to the modulo and falls back to zero (up-down). An end-of-count flag marks every period.

Each of `NCH` channels has a 4-bit mode field that makes it an input capture (rising, falling or both edges), an output compare (clear, set or toggle on match), or a PWM output. PWM is edge-aligned when the counter runs up-only and center-aligned when it runs up-down. In PWM mode a new channel value waits in a buffer until the period boundary. Every register is one byte on a simple single-cycle bus. A shared holding byte and a read snapshot give 16-bit coherence across the byte pairs.

Register map (byte addresses): 0 control {eoc flag[7], up-down[6], source[5:4] (0 off, 1 system, 2 fixed strobe, 3 external pin), ps[2:0]}; 1/2 counter high/low; 3/4 modulo high/low; for channel n, 5+3n status {flag[7], mode[3:0]}, 6+3n value high, 7+3n value low. Modes: 0 idle, 1 capture rise, 2 capture fall, 3 capture both, 4 toggle, 5 clear, 6 set, 8 PWM.

Top module: `capcmp_timer`

## Requirements
- R1: After reset every register reads 0, and `ch_out`, `ch_flag` and `eoc_flag` are 0.
- R2: A write to a high byte (address 1, 3, 6+3n) only loads a holding byte. The 16-bit register changes when its low byte is written. A low-byte read that follows a high-byte read returns the low byte as it was at the high-byte read.
- R3: Source 1 advances on every clock, source 2 on each cycle `fixed_en` is 1, and source 3 on each rising edge of `ext_clk` after synchronization. Source 0 never advances the counter.
- R4: Prescale field ps makes the counter advance once per 2^ps source events (1 to 128).
- R5: In up-only mode the counter counts 0..top and then returns to 0, where top is the modulo, or 0xFFFF when the modulo is 0. The wrap sets `eoc_flag`.
- R6: In up-down mode the counter goes 0..top..0, so a period is 2*top ticks. The turn at zero sets `eoc_flag`.
- R7: Capture modes copy the counter into the channel value on the selected edge of the synchronized `ch_in` and set the channel flag. Other edges leave the value unchanged.
- R8: Compare modes 5, 6 and 4 drive `ch_out` low, high or inverted when the counter steps onto the channel value, and set the channel flag.
- R9: In PWM mode `ch_out` is high while counter < value. With modulo 9 and value 4 this is 40 high cycles in 100 (up-only) and 70 in 180 (up-down, ps 0).
- R10: In PWM mode a written value is read back at once but drives the output only after the next period boundary.
- R11: Flags are sticky. A flag clears only when its register was read while the flag was set and is then written with bit 7 = 0. A write without that read leaves it set.
- R12: Writing either counter byte zeroes the counter and the prescaler and restarts counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fixed_en | input | 1 | Fixed-rate clock strobe, one cycle wide |
| ext_clk | input | 1 | Asynchronous external count clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ch_in | input | NCH | Asynchronous capture inputs |
| ch_out | output | NCH | Compare / PWM outputs |
| ch_flag | output | NCH | Sticky channel flags |
| eoc_flag | output | 1 | Sticky end-of-count flag |

## Verification
The bound checker watches the counter on every cycle. It checks that the counter holds still without a tick, that no tick comes from the off source, the wrap at top in up-only mode, the turn at zero in up-down mode, the stickiness of the end-of-count flag and that a high-byte write leaves the modulo alone. Only the bench scenarios can show the exact PWM duty counts, the period length under each prescale and direction, which capture edges take effect, the delayed buffer load and the read-then-write clear sequence. Those tests use the external pin as the clock so the counter values are exact.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int NCH = 2,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fixed_en,
  input  logic           ext_clk,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] ch_out,
  output logic [NCH-1:0] ch_flag,
  output logic           eoc_flag
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNTH = AW'(1);
  localparam logic [AW-1:0] A_CNTL = AW'(2);
  localparam logic [AW-1:0] A_MODH = AW'(3);
  localparam logic [AW-1:0] A_MODL = AW'(4);
  localparam int A_CH0 = 5;
  localparam logic [3:0] M_CAPR = 4'd1, M_CAPF = 4'd2, M_CAPB = 4'd3;
  localparam logic [3:0] M_TOG = 4'd4, M_CLR = 4'd5, M_SET = 4'd6, M_PWM = 4'd8;

  logic [2:0]  ps;
  logic [1:0]  src;
  logic        updown, dir_up, src_en, tick, upd, eoc_arm, snap_vld, bound;
  logic [15:0] cnt, mod_r, top, rd16;
  logic [6:0]  pcnt, pmask;
  logic [2:0]  ext_s;
  logic [7:0]  wr_hold, rd_snap, rd8;
  logic        is_hi, is_lo, wr_cnt;
  logic [3:0]  mode [NCH];
  logic [15:0] vbuf [NCH];
  logic [15:0] vact [NCH];
  logic [2:0]  in_s [NCH];
  logic [NCH-1:0] ch_arm, cap_ev, hit_ev, is_cmp, is_pwm;

  assign wr_cnt = bus_wr && (bus_addr == A_CNTH || bus_addr == A_CNTL);
  assign top    = (mod_r == 16'd0) ? 16'hFFFF : mod_r;
  assign pmask  = 7'((8'd1 << ps) - 8'd1);
  assign tick   = src_en && ((pcnt & pmask) == pmask);
  assign bound  = tick && (updown ? (!dir_up && cnt == 16'd0) : (cnt >= top));

  always_comb begin
    case (src)
      2'd1:    src_en = 1'b1;
      2'd2:    src_en = fixed_en;
      2'd3:    src_en = ext_s[1] & ~ext_s[2];
      default: src_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; pcnt <= '0; dir_up <= 1'b1; upd <= 1'b0; ext_s <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
      upd   <= tick && !wr_cnt;
      if (wr_cnt) begin
        cnt <= '0; pcnt <= '0; dir_up <= 1'b1;
      end else begin
        if (src_en) pcnt <= pcnt + 7'd1;
        if (tick) begin
          if (!updown) begin
            dir_up <= 1'b1;
            cnt    <= (cnt >= top) ? 16'd0 : cnt + 16'd1;
          end else if (dir_up) begin
            if (cnt >= top) begin dir_up <= 1'b0; cnt <= cnt - 16'd1; end
            else cnt <= cnt + 16'd1;
          end else if (cnt == 16'd0) begin
            dir_up <= 1'b1; cnt <= 16'd1;
          end else cnt <= cnt - 16'd1;
        end
      end
    end
  end

  always_comb begin
    rd8 = '0; rd16 = '0; is_hi = 1'b0; is_lo = 1'b0;
    if (bus_addr == A_CTRL) rd8 = {eoc_flag, updown, src, 1'b0, ps};
    if (bus_addr == A_CNTH) begin rd16 = cnt; is_hi = 1'b1; end
    if (bus_addr == A_CNTL) begin rd16 = cnt; is_lo = 1'b1; end
    if (bus_addr == A_MODH) begin rd16 = mod_r; is_hi = 1'b1; end
    if (bus_addr == A_MODL) begin rd16 = mod_r; is_lo = 1'b1; end
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(A_CH0 + 3*n))     rd8 = {ch_flag[n], 3'b000, mode[n]};
      if (bus_addr == AW'(A_CH0 + 3*n + 1)) begin rd16 = vbuf[n]; is_hi = 1'b1; end
      if (bus_addr == AW'(A_CH0 + 3*n + 2)) begin rd16 = vbuf[n]; is_lo = 1'b1; end
    end
  end
  assign bus_rdata = is_hi ? rd16[15:8] : is_lo ? (snap_vld ? rd_snap : rd16[7:0]) : rd8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= '0; src <= '0; updown <= 1'b0; mod_r <= '0; wr_hold <= '0;
      rd_snap <= '0; snap_vld <= 1'b0; eoc_flag <= 1'b0; eoc_arm <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) begin
        updown <= bus_wdata[6]; src <= bus_wdata[5:4]; ps <= bus_wdata[2:0];
      end
      if (bus_wr && is_hi) wr_hold <= bus_wdata;
      if (bus_wr && bus_addr == A_MODL) mod_r <= {wr_hold, bus_wdata};
      if (bus_rd && is_hi) begin rd_snap <= rd16[7:0]; snap_vld <= 1'b1; end
      else if (bus_rd && is_lo) snap_vld <= 1'b0;
      if (bound) eoc_flag <= 1'b1;
      else if (bus_wr && bus_addr == A_CTRL && !bus_wdata[7] && eoc_arm) eoc_flag <= 1'b0;
      if (bus_rd && bus_addr == A_CTRL && eoc_flag) eoc_arm <= 1'b1;
      else if (bus_wr && bus_addr == A_CTRL) eoc_arm <= 1'b0;
    end
  end

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      is_cmp[n] = (mode[n] == M_TOG) || (mode[n] == M_CLR) || (mode[n] == M_SET);
      is_pwm[n] = (mode[n] == M_PWM);
      hit_ev[n] = upd && (cnt == vact[n]);
      cap_ev[n] = ((mode[n] == M_CAPR || mode[n] == M_CAPB) && in_s[n][1] && !in_s[n][2]) ||
                  ((mode[n] == M_CAPF || mode[n] == M_CAPB) && !in_s[n][1] && in_s[n][2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_out <= '0; ch_flag <= '0; ch_arm <= '0;
      for (int n = 0; n < NCH; n++) begin
        mode[n] <= '0; vbuf[n] <= '0; vact[n] <= '0; in_s[n] <= '0;
      end
    end else begin
      for (int n = 0; n < NCH; n++) begin
        in_s[n] <= {in_s[n][1:0], ch_in[n]};
        if (bus_wr && bus_addr == AW'(A_CH0 + 3*n)) mode[n] <= bus_wdata[3:0];
        if (cap_ev[n]) vbuf[n] <= cnt;
        else if (bus_wr && bus_addr == AW'(A_CH0 + 3*n + 2)) vbuf[n] <= {wr_hold, bus_wdata};
        if (!is_pwm[n] || bound) vact[n] <= vbuf[n];
        if (is_pwm[n]) ch_out[n] <= (cnt < vact[n]);
        else if (is_cmp[n] && hit_ev[n])
          ch_out[n] <= (mode[n] == M_SET) ? 1'b1 : (mode[n] == M_CLR) ? 1'b0 : ~ch_out[n];
        if (cap_ev[n] || ((is_cmp[n] || is_pwm[n]) && hit_ev[n])) ch_flag[n] <= 1'b1;
        else if (bus_wr && bus_addr == AW'(A_CH0 + 3*n) && !bus_wdata[7] && ch_arm[n])
          ch_flag[n] <= 1'b0;
        if (bus_rd && bus_addr == AW'(A_CH0 + 3*n) && ch_flag[n]) ch_arm[n] <= 1'b1;
        else if (bus_wr && bus_addr == AW'(A_CH0 + 3*n)) ch_arm[n] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_cnt,
  input logic [15:0]   cnt,
  input logic [15:0]   top,
  input logic [15:0]   mod_r,
  input logic          updown,
  input logic          dir_up,
  input logic [1:0]    src,
  input logic          eoc_flag,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt)); // R4
  AST_SRC_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0) |-> !tick); // R3
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!updown && tick && !wr_cnt && cnt >= top) |=> (cnt == 16'd0)); // R5
  AST_UPDN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && tick && !wr_cnt && !dir_up && cnt == 16'd0) |=> (cnt == 16'd1)); // R6
  AST_EOC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !(bus_wr && bus_addr == AW'(0))) |=> eoc_flag); // R11
  AST_MOD_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3)) |=> $stable(mod_r)); // R2
  AST_CNT_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == 16'd0)); // R12
endmodule

bind capcmp_timer capcmp_timer_chk #(.AW(AW)) chk_i (.*);

// File: tb/capcmp_timer_tb_top.sv
module capcmp_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, fixed_en = 1'b0, ext_clk = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] ch_in = '0, ch_out, ch_flag;
  logic eoc_flag;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  capcmp_timer dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic wr16(input logic [4:0] a, input logic [15:0] v);
    wr(a, v[15:8]); wr(a + 5'd1, v[7:0]);
  endtask
  task automatic rd16(input logic [4:0] a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(a, h); rd(a + 5'd1, l); v = {h, l};
  endtask
  task automatic ext_pulse(input int k);
    for (int i = 0; i < k; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask
  task automatic set_in(input logic v);
    @(negedge clk); ch_in[0] = v; repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [15:0] v;
    rd(5'd0, b);  check("R1 ctrl", b, 0);
    rd16(5'd1, v); check("R1 counter", v, 0);
    rd16(5'd3, v); check("R1 modulo", v, 0);
    rd(5'd5, b);  check("R1 ch0 status", b, 0);
    check("R1 outputs", {ch_out, ch_flag, eoc_flag}, 0);
  endtask

  task automatic t_coherent;
    logic [15:0] v; logic [7:0] b;
    wr(5'd3, 8'h12);
    rd16(5'd3, v); check("R2 high byte held", v, 0);
    wr(5'd4, 8'h34);
    rd16(5'd3, v); check("R2 low byte commits", v, 16'h1234);
    wr(5'd0, 8'h30); wr(5'd2, 8'h00);
    ext_pulse(3);
    rd(5'd1, b); ext_pulse(2);
    rd(5'd2, b); check("R2 snapshot low", b, 3);
    rd(5'd2, b); check("R2 live low", b, 5);
  endtask

  task automatic t_sources;
    logic [15:0] v;
    wr(5'd0, 8'h20); wr(5'd2, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); fixed_en = 1'b1; @(negedge clk); fixed_en = 1'b0; repeat (2) @(negedge clk);
    end
    rd16(5'd1, v); check("R3 fixed strobe", v, 3);
    wr(5'd0, 8'h21); wr(5'd1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); fixed_en = 1'b1; @(negedge clk); fixed_en = 1'b0; repeat (2) @(negedge clk);
    end
    rd16(5'd1, v); check("R4 prescale 2", v, 2);
    check("R12 prescaler restart", v, 2);
    wr(5'd0, 8'h30); wr(5'd2, 8'h00); ext_pulse(5);
    rd16(5'd1, v); check("R3 external pin", v, 5);
    wr(5'd0, 8'h00); ext_pulse(2);
    rd16(5'd1, v); check("R3 source off", v, 5);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    wr(5'd0, 8'h30); wr(5'd2, 8'h00); ext_pulse(5);
    wr(5'd5, 8'h01); set_in(1'b1);
    rd16(5'd6, v); check("R7 rising capture", v, 5);
    check("R7 capture flag", ch_flag[0], 1);
    ext_pulse(2); set_in(1'b0);
    rd16(5'd6, v); check("R7 falling ignored in rise mode", v, 5);
    wr(5'd5, 8'h02); ext_pulse(1); set_in(1'b1);
    rd16(5'd6, v); check("R7 rising ignored in fall mode", v, 5);
    set_in(1'b0);
    rd16(5'd6, v); check("R7 falling capture", v, 8);
  endtask

  task automatic t_flags;
    logic [7:0] b;
    wr(5'd5, 8'h02);
    check("R11 ch flag kept without read", ch_flag[0], 1);
    rd(5'd5, b); wr(5'd5, 8'h02);
    check("R11 ch flag cleared", ch_flag[0], 0);
    wr16(5'd3, 16'd9); wr(5'd0, 8'h10); repeat (30) @(negedge clk);
    check("R5 eoc set on wrap", eoc_flag, 1);
    wr(5'd0, 8'h00);
    check("R11 eoc kept without read", eoc_flag, 1);
    rd(5'd0, b); wr(5'd0, 8'h00);
    check("R11 eoc cleared", eoc_flag, 0);
  endtask

  task automatic t_compare;
    wr(5'd0, 8'h10); wr16(5'd3, 16'd9); wr(5'd5, 8'h00); wr16(5'd6, 16'd3);
    wr(5'd5, 8'h05); repeat (30) @(negedge clk);
    check("R8 clear on match", ch_out[0], 0);
    wr(5'd5, 8'h06); repeat (30) @(negedge clk);
    check("R8 set on match", ch_out[0], 1);
    check("R8 compare flag", ch_flag[0], 1);
    wr(5'd5, 8'h05); repeat (30) @(negedge clk);
    check("R8 clear again", ch_out[0], 0);
  endtask

  task automatic count_high(input int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin @(negedge clk); if (ch_out[0]) hi++; end
  endtask

  task automatic t_pwm;
    int hi;
    wr(5'd0, 8'h10); wr16(5'd3, 16'd9); wr(5'd5, 8'h00); wr16(5'd6, 16'd4);
    wr(5'd5, 8'h08); repeat (40) @(negedge clk);
    count_high(100, hi); check("R9 edge-aligned duty", hi, 40);
    wr(5'd0, 8'h50); repeat (60) @(negedge clk);
    count_high(180, hi); check("R9 center-aligned duty", hi, 70);
  endtask

  task automatic period(output int cyc);
    logic p;
    p = ch_out[0];
    while (ch_out[0] == p) @(negedge clk);
    p = ch_out[0]; cyc = 0;
    while (ch_out[0] == p) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_period;
    int c;
    wr(5'd5, 8'h00); wr16(5'd6, 16'd9); wr16(5'd3, 16'd9);
    wr(5'd0, 8'h10); wr(5'd5, 8'h04);
    period(c); check("R5 up period modulo 9", c, 10);
    wr(5'd0, 8'h12);
    period(c); period(c); check("R4 prescale 4 period", c, 40);
    wr(5'd0, 8'h50);
    period(c); period(c); check("R6 up-down period", c, 18);
  endtask

  task automatic t_buffer;
    logic [15:0] v;
    wr(5'd0, 8'h30); wr16(5'd3, 16'd9); wr(5'd5, 8'h00); wr16(5'd6, 16'd4);
    wr(5'd2, 8'h00); wr(5'd5, 8'h08);
    ext_pulse(2); wr16(5'd6, 16'd8);
    rd16(5'd6, v); check("R10 buffer readback", v, 8);
    ext_pulse(3); check("R10 old value until boundary", ch_out[0], 0);
    ext_pulse(10); check("R10 new value after boundary", ch_out[0], 1);
  endtask

  initial begin
    repeat (4) @(negedge clk); rst_n = 1'b1;
    t_reset; t_coherent; t_sources; t_capture; t_flags;
    t_compare; t_pwm; t_period; t_buffer;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule